// File: doc/BRIEF.md
# UART Register and Status Front End

This block is the software-visible register file of a serial port. A host reaches it over a simple synchronous bus. The bus carries a request strobe, a write flag, a 12-bit byte offset and 32-bit data. Read data comes back in the cycle after the request.

Behind the bus the block holds a transmit queue and a receive queue. The serial shifter outside the block pushes each received character into the receive queue together with its four error flags, and it pops characters from the transmit queue. The block also keeps a latched copy of the error flags of the last character read, a status flag word, the line-control and control words, and a raw/mask/masked interrupt set that drives one interrupt line.

One bit of the line-control word chooses the queue mode. With the bit set, each queue is a 16-entry FIFO. With it clear, each queue is a single holding register.

Top module: `uart_regfile`

## Requirements
- R1: After reset, offset 0x018 reads 0x090 when all modem inputs and the busy input are low. Offset 0x004 and offset 0x02C read 0. Offset 0x03C reads 0x020. Offset 0x040 reads 0, and `irq_o` is low.
- R2: A write to offset 0x000 queues `wdata_i[7:0]` for transmission. `tx_data_o` shows the oldest queued character while `tx_valid_o` is high, and each `tx_pop_i` pulse advances to the next character in write order.
- R3: A read of offset 0x000 pops the oldest receive word and returns it as the character in bits 7..0, framing error in bit 8, parity error in bit 9, break in bit 10 and overrun in bit 11. A read while the receive queue is empty returns 0 and changes no state.
- R4: Offset 0x004 bits 3..0 are loaded with bits 11..8 of the word popped by a data read, and with nothing else. Reads of other offsets leave it unchanged.
- R5: Any write to offset 0x004 clears it to 0, whatever the written data.
- R6: The flag word at 0x018 carries CTS at bit 0, DSR at bit 1, DCD at bit 2, busy at bit 3, receive-empty at bit 4, transmit-full at bit 5, receive-full at bit 6, transmit-empty at bit 7 and RI at bit 8. The modem pins and busy follow the inputs directly.
- R7: With bit 4 of offset 0x02C clear, each queue is full after one entry and drops further pushes. With the bit set, each queue takes 16 entries.
- R8: The control word at 0x030 resets to 0x0300. Bits 6..3 and 31..16 read as zero. The other bits of bits 15..0 read back as written and drive `ctrl_o`.
- R9: Raw interrupt bits at 0x03C are as follows. RI is bit 0, CTS is bit 1, DCD is bit 2 and DSR is bit 3; each of these sets on any change of its modem pin. Bit 6 sets on a receive-timeout pulse. Bits 7, 8, 9 and 10 set when an accepted receive word carries framing, parity, break or overrun respectively. Bit 4 is high while the receive queue is not empty, and bit 5 is high while the transmit queue is empty.
- R10: Offset 0x040 reads the raw bits ANDed with the mask at 0x038. `irq_o` is the OR of the masked bits.
- R11: Writing offset 0x044 clears each raw bit whose data bit is 1. Data bits at 0 have no effect, and level bits 4 and 5 are never cleared by this write.
- R12: A receive push while the receive queue is full drops the word and sets raw bit 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read |
| rx_push_i | input | 1 | Receive word strobe from the shifter |
| rx_data_i | input | 8 | Received character |
| rx_err_i | input | 4 | Errors {overrun, break, parity, framing} |
| rx_timeout_i | input | 1 | Receive-timeout pulse |
| tx_pop_i | input | 1 | Shifter takes the head character |
| tx_data_o | output | 8 | Head of the transmit queue |
| tx_valid_o | output | 1 | Transmit queue not empty |
| modem_i | input | 4 | {RI, DCD, DSR, CTS} pin levels |
| busy_i | input | 1 | Shifter busy |
| ctrl_o | output | 16 | Control word |
| line_ctrl_o | output | 8 | Line-control word |
| irq_o | output | 1 | Combined interrupt |

## Verification
A bus read samples state at the clock edge where its request is seen, and the result appears on `rdata_o` one cycle later. Writes, pushes and pops take effect at that same edge, so any state they cause can be read at the next request. `irq_o` and `tx_data_o` follow stored state without further delay. The bench drives all inputs on falling edges and holds each for one rising edge. It samples on the following falling edge, which is exactly one register stage after the edge that acted. Expected queue contents, flag words and interrupt words come from bench-side queue models and helper functions.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  localparam logic [11:0] OFF_DR   = 12'h000;
  localparam logic [11:0] OFF_RSR  = 12'h004;
  localparam logic [11:0] OFF_FR   = 12'h018;
  localparam logic [11:0] OFF_LCR  = 12'h02C;
  localparam logic [11:0] OFF_CR   = 12'h030;
  localparam logic [11:0] OFF_IMSC = 12'h038;
  localparam logic [11:0] OFF_RIS  = 12'h03C;
  localparam logic [11:0] OFF_MIS  = 12'h040;
  localparam logic [11:0] OFF_ICR  = 12'h044;

  localparam int unsigned IRQ_W    = 11;
  localparam int unsigned IRQ_RX   = 4;
  localparam int unsigned IRQ_TX   = 5;
  localparam int unsigned IRQ_RT   = 6;
  localparam int unsigned IRQ_ERR0 = 7;   // FE, PE, BE, OE follow
  localparam int unsigned IRQ_OE   = 10;

  localparam int unsigned LCR_FEN  = 4;
  localparam logic [15:0] CR_RST   = 16'h0300;
  localparam logic [15:0] CR_WMASK = 16'hFF87;

  typedef struct packed {
    logic ri;
    logic txfe;
    logic rxff;
    logic txff;
    logic rxfe;
    logic busy;
    logic dcd;
    logic dsr;
    logic cts;
  } flags_t;
endpackage

// File: rtl/uart_rf_fifo.sv
module uart_rf_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fifo_mode_i,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic [CW-1:0] limit;
  logic          push_ok, pop_ok;

  assign limit   = fifo_mode_i ? CW'(DEPTH) : CW'(1);
  assign empty_o = (count == '0);
  assign full_o  = (count >= limit);
  assign push_ok = push_i & ~full_o;
  assign pop_ok  = pop_i & ~empty_o;
  assign data_o  = mem[rd_ptr];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= nxt(wr_ptr);
      if (pop_ok)  rd_ptr <= nxt(rd_ptr);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  // R7
  depth_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= CW'(DEPTH));
  // R7
  hold_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_mode_i && count != '0 && push_i && !pop_i) |=> count == $past(count));
  // R3
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && !push_i) |=> empty_o);
endmodule

// File: rtl/uart_rf_irq.sv
module uart_rf_irq
  import uart_rf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       modem_i,      // {ri, dcd, dsr, cts}
  input  logic             rx_nonempty_i,
  input  logic             tx_empty_i,
  input  logic             rx_timeout_i,
  input  logic             rx_accept_i,
  input  logic [3:0]       rx_err_i,
  input  logic             rx_drop_i,
  input  logic [IRQ_W-1:0] mask_i,
  input  logic             clr_we_i,
  input  logic [IRQ_W-1:0] clr_i,
  output logic [IRQ_W-1:0] ris_o,
  output logic [IRQ_W-1:0] mis_o,
  output logic             irq_o
);
  logic [3:0]       modem_q, chg;
  logic [IRQ_W-1:0] raw_q, set_v, clr_v;

  assign chg = modem_i ^ modem_q;

  always_comb begin
    set_v = '0;
    set_v[0] = chg[3];
    set_v[1] = chg[0];
    set_v[2] = chg[2];
    set_v[3] = chg[1];
    set_v[IRQ_RT] = rx_timeout_i;
    for (int i = 0; i < 4; i++) set_v[IRQ_ERR0+i] = rx_accept_i & rx_err_i[i];
    set_v[IRQ_OE] = set_v[IRQ_OE] | rx_drop_i;
    clr_v = clr_we_i ? clr_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      modem_q <= '0;
      raw_q   <= '0;
    end else begin
      modem_q <= modem_i;
      raw_q   <= ((raw_q & ~clr_v) | set_v) & ~(IRQ_W'(3) << IRQ_RX);
    end
  end

  always_comb begin
    ris_o = raw_q;
    ris_o[IRQ_RX] = rx_nonempty_i;
    ris_o[IRQ_TX] = tx_empty_i;
  end
  assign mis_o = ris_o & mask_i;
  assign irq_o = |mis_o;

  // R12
  overrun_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_drop_i |=> ris_o[IRQ_OE]);
  // R10
  masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '0) |-> !irq_o);
  // R11
  fe_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && clr_i[IRQ_ERR0] && !rx_accept_i) |=> !ris_o[IRQ_ERR0]);
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_rf_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [11:0] addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        rx_push_i,
  input  logic [7:0]  rx_data_i,
  input  logic [3:0]  rx_err_i,
  input  logic        rx_timeout_i,
  input  logic        tx_pop_i,
  output logic [7:0]  tx_data_o,
  output logic        tx_valid_o,
  input  logic [3:0]  modem_i,
  input  logic        busy_i,
  output logic [15:0] ctrl_o,
  output logic [7:0]  line_ctrl_o,
  output logic        irq_o
);
  logic             acc_rd, acc_wr, sel_dr;
  logic             rx_empty, rx_full, tx_empty, tx_full, fifo_mode;
  logic [11:0]      rx_head;
  logic [3:0]       rsr_q;
  logic [7:0]       lcr_q;
  logic [15:0]      cr_q;
  logic [IRQ_W-1:0] imsc_q, ris, mis;
  logic [31:0]      rd_mux, rdata_q;
  flags_t           flags;
  logic             unused_wdata;

  assign acc_rd    = req_i & ~we_i;
  assign acc_wr    = req_i & we_i;
  assign sel_dr    = (addr_i == OFF_DR);
  assign fifo_mode = lcr_q[LCR_FEN];
  assign unused_wdata = ^wdata_i[31:16];

  uart_rf_fifo #(.W(12), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni, .fifo_mode_i(fifo_mode),
    .push_i(rx_push_i), .data_i({rx_err_i, rx_data_i}),
    .pop_i(acc_rd & sel_dr), .data_o(rx_head),
    .empty_o(rx_empty), .full_o(rx_full));

  uart_rf_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni, .fifo_mode_i(fifo_mode),
    .push_i(acc_wr & sel_dr), .data_i(wdata_i[7:0]),
    .pop_i(tx_pop_i), .data_o(tx_data_o),
    .empty_o(tx_empty), .full_o(tx_full));

  uart_rf_irq u_irq (
    .clk_i, .rst_ni, .modem_i,
    .rx_nonempty_i(~rx_empty), .tx_empty_i(tx_empty),
    .rx_timeout_i, .rx_accept_i(rx_push_i & ~rx_full), .rx_err_i,
    .rx_drop_i(rx_push_i & rx_full), .mask_i(imsc_q),
    .clr_we_i(acc_wr && addr_i == OFF_ICR), .clr_i(wdata_i[IRQ_W-1:0]),
    .ris_o(ris), .mis_o(mis), .irq_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsr_q  <= '0;
      lcr_q  <= '0;
      cr_q   <= CR_RST;
      imsc_q <= '0;
    end else begin
      if (acc_wr) begin
        unique case (addr_i)
          OFF_RSR:  rsr_q  <= '0;
          OFF_LCR:  lcr_q  <= wdata_i[7:0];
          OFF_CR:   cr_q   <= wdata_i[15:0] & CR_WMASK;
          OFF_IMSC: imsc_q <= wdata_i[IRQ_W-1:0];
          default: ;
        endcase
      end else if (acc_rd && sel_dr && !rx_empty) begin
        rsr_q <= rx_head[11:8];
      end
    end
  end

  always_comb begin
    flags      = '0;
    flags.cts  = modem_i[0];
    flags.dsr  = modem_i[1];
    flags.dcd  = modem_i[2];
    flags.ri   = modem_i[3];
    flags.busy = busy_i;
    flags.rxfe = rx_empty;
    flags.txff = tx_full;
    flags.rxff = rx_full;
    flags.txfe = tx_empty;
  end

  always_comb begin
    rd_mux = '0;
    unique case (addr_i)
      OFF_DR:   rd_mux = rx_empty ? '0 : {20'b0, rx_head};
      OFF_RSR:  rd_mux = {28'b0, rsr_q};
      OFF_FR:   rd_mux = {23'b0, flags};
      OFF_LCR:  rd_mux = {24'b0, lcr_q};
      OFF_CR:   rd_mux = {16'b0, cr_q};
      OFF_IMSC: rd_mux = {21'b0, imsc_q};
      OFF_RIS:  rd_mux = {21'b0, ris};
      OFF_MIS:  rd_mux = {21'b0, mis};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (acc_rd) rdata_q <= rd_mux;
  end

  assign rdata_o     = rdata_q;
  assign tx_valid_o  = ~tx_empty;
  assign ctrl_o      = cr_q;
  assign line_ctrl_o = lcr_q;

  // R4
  rsr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && (addr_i == OFF_DR || addr_i == OFF_RSR)) |=> $stable(rsr_q));
  // R5
  rsr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_wr && addr_i == OFF_RSR) |=> rsr_q == '0);
  // R3
  empty_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_rd && sel_dr && rx_empty) |=> rdata_o == '0);
endmodule

// File: tb/sim_uart_regfile.sv
`timescale 1ns/1ps
module sim_uart_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 0, we = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rx_push = 0, rx_to = 0, tx_pop = 0, busy = 0;
  logic [7:0]  rx_data = '0;
  logic [3:0]  rx_err = '0, modem = '0;
  logic [7:0]  tx_data, lcr_o;
  logic        tx_valid, irq;
  logic [15:0] ctrl;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_regfile u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rx_push_i(rx_push), .rx_data_i(rx_data),
    .rx_err_i(rx_err), .rx_timeout_i(rx_to), .tx_pop_i(tx_pop),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .modem_i(modem), .busy_i(busy),
    .ctrl_o(ctrl), .line_ctrl_o(lcr_o), .irq_o(irq));

  function automatic logic [31:0] exp_fr(logic [3:0] m, logic b, logic rxe,
                                         logic txf, logic rxf, logic txe);
    return {23'b0, m[3], txe, rxf, txf, rxe, b, m[2], m[1], m[0]};
  endfunction

  function automatic logic [31:0] exp_mis(logic [31:0] r, logic [31:0] m);
    return r & m & 32'h7FF;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0; d = rdata;
  endtask

  task automatic push(input logic [3:0] e, input logic [7:0] c);
    @(negedge clk); rx_push = 1; rx_err = e; rx_data = c;
    @(negedge clk); rx_push = 0;
  endtask

  task automatic pop_tx();
    @(negedge clk); tx_pop = 1;
    @(negedge clk); tx_pop = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [11:0] q [16];
    logic [7:0]  tq [16];
    logic [3:0]  eor;
    int n;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(12'h018, v); chk("R1/R6 flags", v, exp_fr(4'h0, 0, 1, 0, 0, 1));
    rd(12'h030, v); chk("R1/R8 ctrl", v, 32'h300);
    rd(12'h004, v); chk("R1 rsr", v, 0);
    rd(12'h02C, v); chk("R1 lcr", v, 0);
    rd(12'h03C, v); chk("R1/R9 ris", v, 32'h020);
    rd(12'h040, v); chk("R1 mis", v, 0);
    chk("R1 irq", irq, 0);

    // R7 holding mode
    wr(12'h000, 32'h41);
    rd(12'h018, v); chk("R7 tx hold full", v, exp_fr(4'h0, 0, 1, 1, 0, 0));
    wr(12'h000, 32'h42);
    chk("R2 tx head", tx_data, 8'h41);
    pop_tx();
    chk("R7 second char dropped", tx_valid, 0);
    push(4'h0, 8'h11);
    rd(12'h018, v); chk("R7 rx hold full", v, exp_fr(4'h0, 0, 0, 0, 1, 1));
    push(4'h0, 8'h22);
    rd(12'h03C, v); chk("R12 overrun set", v, 32'h430);
    rd(12'h000, v); chk("R3 pop holding", v, 32'h011);
    rd(12'h000, v); chk("R3 empty read", v, 0);
    rd(12'h004, v); chk("R3/R4 rsr after empty read", v, 0);
    wr(12'h044, 32'h7FF);
    rd(12'h03C, v); chk("R11 clear keeps levels", v, 32'h020);

    // FIFO mode, random rx rounds
    wr(12'h02C, 32'h10);
    rd(12'h02C, v); chk("R7 lcr readback", v, 32'h10);
    for (int r = 0; r < 6; r++) begin
      n = 1 + ($urandom % 16);
      eor = '0;
      for (int i = 0; i < n; i++) begin
        q[i] = 12'($urandom);
        eor |= q[i][11:8];
        push(q[i][11:8], q[i][7:0]);
      end
      rd(12'h03C, v); chk("R9 error raw bits", v, 32'h030 | (32'(eor) << 7));
      rd(12'h018, v);
      chk("R6/R7 rx fill flags", v, exp_fr(4'h0, 0, 0, 0, n == 16, 1));
      for (int i = 0; i < n; i++) begin
        rd(12'h000, v); chk("R3 fifo pop", v, {20'b0, q[i]});
        rd(12'h004, v); chk("R4 rsr follows pop", v, {28'b0, q[i][11:8]});
      end
      wr(12'h044, 32'h7FF);
    end

    // R12 full fifo overrun, R7 depth 16
    for (int i = 0; i < 16; i++) push(4'h0, 8'(i + 8'h30));
    rd(12'h018, v); chk("R7 rx 16 full", v, exp_fr(4'h0, 0, 0, 0, 1, 1));
    push(4'h0, 8'hEE);
    rd(12'h03C, v); chk("R12 fifo overrun", v, 32'h430);
    for (int i = 0; i < 16; i++) begin
      rd(12'h000, v); chk("R3 ordered pop", v, 32'(i + 8'h30));
    end
    rd(12'h000, v); chk("R12 dropped word absent", v, 0);

    // R4 / R5
    push(4'hA, 8'h5A);
    rd(12'h000, v); chk("R3 error field order", v, 32'hA5A);
    rd(12'h018, v);
    rd(12'h004, v); chk("R4 unchanged by other read", v, 32'hA);
    wr(12'h004, 32'h0);
    rd(12'h004, v); chk("R5 any write clears", v, 0);
    wr(12'h044, 32'h7FF);

    // R2 random tx
    n = 1 + ($urandom % 15);
    for (int i = 0; i < n; i++) begin
      tq[i] = 8'($urandom);
      wr(12'h000, {24'b0, tq[i]});
    end
    for (int i = 0; i < n; i++) begin
      chk("R2 tx order", tx_data, tq[i]);
      pop_tx();
    end
    chk("R2 tx drained", tx_valid, 0);
    for (int i = 0; i < 16; i++) wr(12'h000, 32'(i));
    rd(12'h018, v); chk("R7 tx 16 full", v, exp_fr(4'h0, 0, 1, 1, 0, 0));
    for (int i = 0; i < 16; i++) pop_tx();

    // R8 control word
    wr(12'h030, 32'hFFFF_FFFF);
    rd(12'h030, v); chk("R8 reserved zero", v, 32'hFF87);
    chk("R8 ctrl_o", ctrl, 16'hFF87);

    // R9/R10/R11 modem and masking
    @(negedge clk); modem = 4'b0001;
    rd(12'h018, v); chk("R6 cts pin", v, exp_fr(4'b0001, 0, 1, 0, 0, 1));
    rd(12'h03C, v); chk("R9 cts change", v, 32'h022);
    wr(12'h038, 32'h002);
    rd(12'h040, v); chk("R10 masked", v, exp_mis(32'h022, 32'h002));
    chk("R10 irq high", irq, 1);
    wr(12'h044, 32'h0);
    rd(12'h03C, v); chk("R11 zero write no effect", v, 32'h022);
    wr(12'h044, 32'h002);
    rd(12'h03C, v); chk("R11 w1c", v, 32'h020);
    chk("R10 irq low", irq, 0);
    wr(12'h038, 32'h020);
    chk("R10 tx level irq", irq, 1);
    wr(12'h038, 32'h000);
    @(negedge clk); modem = 4'b1000; busy = 1;
    rd(12'h018, v); chk("R6 ri and busy", v, exp_fr(4'b1000, 1, 1, 0, 0, 1));
    rd(12'h03C, v); chk("R9 ri and cts change", v, 32'h023);
    wr(12'h044, 32'h7FF);
    @(negedge clk); rx_to = 1;
    @(negedge clk); rx_to = 0;
    rd(12'h03C, v); chk("R9 timeout", v, 32'h060);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule